// File: doc/BRIEF.md
# DMA Completion Interrupt Mapper

This block turns per-channel DMA completion pulses into interrupt requests. A small number of routed interrupt lines each watch one programmable channel: every routed line holds a 5-bit channel selector and an enable bit. When the enabled line's chosen channel reports completion, the line pulses for one clock.

Completions that no enabled routed line claims go to a shared interrupt instead. They set bits in a sticky per-channel flag vector, and the shared interrupt stays high while any flag is set. Software reads the flag vector to find out which channels finished. It clears flags by writing ones to a separate clear location.

The register port is a plain single-cycle write strobe with address and data, plus a combinational read path. Any bus protocol is decoded outside the block.

Top module: `dma_irq_mapper`

## Requirements
- R1: After reset every routed configuration is zero, the flag vector is zero, every routed line and the shared interrupt are low, and every readable location reads 0.
- R2: Word address k (0 to NUM_MAP-1) holds the configuration of routed line k. Bits 4:0 are the channel selector and bit 5 is the enable. A read returns these six bits with all higher bits zero, and write data above bit 5 is dropped.
- R3: A routed line with enable 1 is high in the cycle after the clock edge that samples a completion pulse on its selected channel. It is high for exactly one cycle per pulse, and two lines that select the same channel pulse together.
- R4: A routed line whose enable bit is 0 stays low, even when its selected channel completes.
- R5: Word address NUM_MAP reads the flag vector, with bit n for channel n. A completion on channel n sets bit n unless an enabled routed line selects channel n, in which case the bit is left unchanged. Writes to this address have no effect.
- R6: The shared interrupt output is high exactly while at least one flag bit is set.
- R7: Writing to word address NUM_MAP+1 clears every flag bit whose data bit is 1 and leaves bits written as 0 untouched. This address reads as 0.
- R8: When a completion and a clear hit the same flag bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | NUM_CH | Per-channel completion pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write word address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read word address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| map_irq_o | output | NUM_MAP | Routed interrupt pulses |
| agg_irq_o | output | 1 | Shared interrupt, level |
| flags_o | output | NUM_CH | Sticky per-channel flag vector |

## Verification
A completion that sets a flag bit and a software clear of that same bit can land in the same clock. The bench provokes this with a table step that drives a channel's completion pulse and a clear write naming that channel on one edge. It judges the case as correct when the bit still reads as set, and therefore the shared interrupt is still high, on the following cycle. A second table step clears a set bit while another channel completes. This shows that the set priority applies per bit and does not block the clear of other bits.

// File: rtl/dma_irqmap_pkg.sv
package dma_irqmap_pkg;

  localparam int unsigned SEL_W = 5;
  localparam int unsigned SEL_SPAN = 1 << SEL_W;
  localparam int unsigned CFG_W = SEL_W + 1;

  // Configuration word layout: bit 5 enable, bits 4:0 channel selector.
  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } map_cfg_t;

endpackage

// File: rtl/irqmap_slot.sv
module irqmap_slot
  import dma_irqmap_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  map_cfg_t          wr_cfg_i,
  input  logic [NUM_CH-1:0] done_i,
  output map_cfg_t          cfg_o,
  output logic              irq_o
);

  map_cfg_t cfg_q, cfg_d;
  logic     irq_q, irq_d;
  logic [SEL_SPAN-1:0] done_ext;
  logic     sel_valid;

  assign done_ext  = SEL_SPAN'(done_i);
  assign sel_valid = (32'(cfg_q.sel) < NUM_CH);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      cfg_d = wr_cfg_i;
    end
    irq_d = cfg_q.en & sel_valid & done_ext[cfg_q.sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      irq_q <= irq_d;
    end
  end

  assign cfg_o = cfg_q;
  assign irq_o = irq_q;

  // R4: a slot that was disabled never pulses in the following cycle
  p_disabled_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |=> !irq_o)
    else $error("p_disabled_silent_r4");

endmodule

// File: rtl/irqmap_flags.sv
module irqmap_flags #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flags_o
);

  logic [NUM_CH-1:0] flags_q, flags_d;

  always_comb begin
    // Set takes precedence over clear for the same bit.
    flags_d = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // R8: every bit requested for setting is set next cycle, whatever the clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)))
    else $error("p_set_wins_r8");

  // R7: a set bit can only fall when its clear bit was written
  p_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) |=> (((flags_q | $past(clr_i)) & $past(flags_q)) == $past(flags_q)))
    else $error("p_clear_only_r7");

endmodule

// File: rtl/dma_irq_mapper.sv
module dma_irq_mapper
  import dma_irqmap_pkg::*;
#(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned NUM_MAP = 3,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  done_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_MAP-1:0] map_irq_o,
  output logic               agg_irq_o,
  output logic [NUM_CH-1:0]  flags_o
);

  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_MAP);
  localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(NUM_MAP + 1);

  map_cfg_t            cfg    [NUM_MAP];
  map_cfg_t            wr_cfg;
  logic [NUM_CH-1:0]   routed;
  logic [NUM_CH-1:0]   flag_set;
  logic [NUM_CH-1:0]   flag_clr;
  logic [NUM_CH-1:0]   flags;
  logic                unused_wr_hi;

  assign wr_cfg       = map_cfg_t'(wr_data_i[CFG_W-1:0]);
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:CFG_W];

  generate
    for (genvar k = 0; k < NUM_MAP; k++) begin : g_slot
      logic slot_wr;
      assign slot_wr = wr_en_i & (wr_addr_i == ADDR_W'(k));
      irqmap_slot #(.NUM_CH(NUM_CH)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (slot_wr),
        .wr_cfg_i (wr_cfg),
        .done_i   (done_i),
        .cfg_o    (cfg[k]),
        .irq_o    (map_irq_o[k])
      );
    end
  endgenerate

  // Channels claimed by an enabled routed line.
  always_comb begin
    logic [SEL_SPAN-1:0] claim;
    claim = '0;
    for (int k = 0; k < NUM_MAP; k++) begin
      if (cfg[k].en) begin
        claim[cfg[k].sel] = 1'b1;
      end
    end
    routed = claim[NUM_CH-1:0];
  end

  always_comb begin
    flag_set = done_i & ~routed;
    flag_clr = '0;
    if (wr_en_i && (wr_addr_i == CLR_ADDR)) begin
      flag_clr = wr_data_i[NUM_CH-1:0];
    end
  end

  irqmap_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  assign flags_o   = flags;
  assign agg_irq_o = |flags;

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_MAP; k++) begin
      if (rd_addr_i == ADDR_W'(k)) begin
        rd_data_o = DATA_W'(cfg[k]);
      end
    end
    if (rd_addr_i == FLAG_ADDR) begin
      rd_data_o = DATA_W'(flags);
    end
  end

  // R3: a routed pulse always follows a completion in the previous cycle
  p_pulse_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|map_irq_o) |-> $past(|done_i))
    else $error("p_pulse_needs_done_r3");

  // R5: a claimed completion never raises a flag that was clear
  p_routed_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_i & routed & ~flags)) |=> ((flags & $past(done_i & routed & ~flags)) == '0))
    else $error("p_routed_no_flag_r5");

  // R6: shared interrupt follows the flag vector
  p_agg_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    agg_irq_o == (flags_o != '0))
    else $error("p_agg_level_r6");

endmodule

// File: tb/dma_irq_mapper_tb.sv
module dma_irq_mapper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] done;
    logic [31:0] clr;
    logic [2:0]  map;
    logic [31:0] flags;
  } vec_t;

  // Slot0: channel 3 enabled; slot1: channel 10 enabled; slot2: channel 3 disabled.
  localparam vec_t VEC [0:7] = '{
    '{32'h0000_0001, 32'h0,         3'b000, 32'h0000_0001},
    '{32'h0000_0008, 32'h0,         3'b001, 32'h0000_0001},
    '{32'h0000_0408, 32'h0,         3'b011, 32'h0000_0001},
    '{32'h8000_0010, 32'h0,         3'b000, 32'h8000_0011},
    '{32'h0000_0002, 32'h0000_0001, 3'b000, 32'h8000_0012},
    '{32'h0000_0010, 32'h0000_0010, 3'b000, 32'h8000_0012},
    '{32'h0,         32'hFFFF_FFFF, 3'b000, 32'h0},
    '{32'hFFFF_FFFF, 32'h0,         3'b011, 32'hFFFF_FBF7}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] done_i;
  logic        wr_en_i;
  logic [2:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [2:0]  rd_addr_i;
  logic [31:0] rd_data_o;
  logic [2:0]  map_irq_o;
  logic        agg_irq_o;
  logic [31:0] flags_o;

  int checks;
  int failures;

  dma_irq_mapper u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (done_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .map_irq_o (map_irq_o),
    .agg_irq_o (agg_irq_o),
    .flags_o   (flags_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] addr, input logic [31:0] data);
    wr_en_i   = 1'b1;
    wr_addr_i = addr;
    wr_data_i = data;
    step();
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic reg_read(input logic [2:0] addr, output logic [31:0] data);
    rd_addr_i = addr;
    #1;
    data = rd_data_o;
  endtask

  initial begin
    logic [31:0] rd;
    checks    = 0;
    failures  = 0;
    rst_n     = 1'b0;
    done_i    = '0;
    wr_en_i   = 1'b0;
    wr_addr_i = '0;
    wr_data_i = '0;
    rd_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1: reset state
    check("R1 map", 32'(map_irq_o), 32'h0);
    check("R1 agg", 32'(agg_irq_o), 32'h0);
    check("R1 flags", flags_o, 32'h0);
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), rd);
      check("R1 readback", rd, 32'h0);
    end

    // R2: field layout and upper bits dropped
    reg_write(3'd0, 32'hFFFF_FFC5);
    reg_read(3'd0, rd);
    check("R2 upper dropped", rd, 32'h0000_0005);
    reg_write(3'd1, 32'h0000_0023);
    reg_read(3'd1, rd);
    check("R2 enable+sel", rd, 32'h0000_0023);

    // R5: writes to the flag address have no effect
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_read(3'd3, rd);
    check("R5 flag addr write ignored", rd, 32'h0);
    // R7: clear address reads zero
    reg_read(3'd4, rd);
    check("R7 clear addr reads 0", rd, 32'h0);

    reg_write(3'd0, 32'h0000_0023);
    reg_write(3'd1, 32'h0000_002A);
    reg_write(3'd2, 32'h0000_0003);

    // Table walk: R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      done_i = VEC[i].done;
      if (VEC[i].clr != 0) begin
        wr_en_i   = 1'b1;
        wr_addr_i = 3'd4;
        wr_data_i = VEC[i].clr;
      end
      step();
      done_i  = '0;
      wr_en_i = 1'b0;
      check($sformatf("R3/R4 map step %0d", i), 32'(map_irq_o), 32'(VEC[i].map));
      check($sformatf("R5/R7/R8 flags step %0d", i), flags_o, VEC[i].flags);
      check($sformatf("R6 agg step %0d", i), 32'(agg_irq_o), 32'(VEC[i].flags != 0));
      step();
      check($sformatf("R3 single pulse step %0d", i), 32'(map_irq_o), 32'h0);
    end

    // R5: flag vector readable at its address
    reg_read(3'd3, rd);
    check("R5 flag read", rd, 32'hFFFF_FBF7);

    // R7: partial clear leaves zero-written bits
    reg_write(3'd4, 32'h0000_FFFF);
    check("R7 partial clear", flags_o, 32'hFFFF_0000);
    reg_write(3'd4, 32'hFFFF_0000);
    check("R6 agg low when empty", 32'(agg_irq_o), 32'h0);

    // R4: only the disabled slot selects channel 3 now
    reg_write(3'd0, 32'h0000_0000);
    done_i = 32'h0000_0008;
    step();
    done_i = '0;
    check("R4 disabled slot silent", 32'(map_irq_o), 32'h0);
    check("R5 unclaimed sets flag", flags_o, 32'h0000_0008);

    // R1: mid-run reset clears flags and configuration
    rst_n = 1'b0;
    #1;
    check("R1 async reset flags", flags_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    reg_read(3'd1, rd);
    check("R1 reset config", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule